// File: doc/BRIEF.md
# Multi-Channel Asynchronous Memory Bus Controller

This block produces external access cycles for asynchronous memories and slow peripherals spread over eight chip-select channels. Every channel owns a small configuration register (strobe wait count, setup/hold count, page-mode enable and strobe polarity). A single cycle engine is shared by all channels. When a request is accepted, the selected channel's configuration is copied into the engine, and the whole access runs from that copy. A single access can be stretched from 3 to well over 360 clocks.

An access asserts the channel's select and drives the address (and write data), waits the setup/hold interval, pulses the read or write strobe for the wait interval, waits the setup/hold interval again with the address held, then releases the select and acknowledges. In page mode the setup/hold interval is skipped. Several beats then run back to back under one select, and only the strobe toggles between them. Channels 0 to 5 drive active-low select pins. Channels 6 and 7 drive internal active-high selects meant for alternate uses.

Top module: `amem_ctrl`

## Requirements
- R1: Each of the eight channels has its own configuration register, written when `cfg_we` is high at a clock edge, with layout `cfg_data[7:0]` wait count W, `[13:8]` setup/hold count S, `[14]` page enable, `[15]` strobe polarity. All zero after reset. Every access uses the values of its own channel.
- R2: `req_ready` is high only when the engine is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low from there until the cycle after `ack`. A request held high during a busy period is taken only after that access completes, and does not disturb the running access.
- R3: A non-page access, counted in clocks after the accepting edge, shows S clocks with the select active and the strobe inactive, then W+1 clocks of strobe, then S clocks with the select active and the strobe inactive, then one `ack` clock with the select released. This totals 2S+W+3 clocks including the accepting clock, from 3 up to 384.
- R4: The configuration is copied at acceptance, so a write to the running channel's register during an access leaves that access's timing unchanged, and the next access uses the new value.
- R5: In page mode, with B = `req_beats`+1 beats, there is no setup or hold interval. Each beat has W+1 strobe clocks, and one clock with the strobe inactive and the select still active lies between beats. Beat k drives address `req_addr`+k.
- R6: When page mode is off, `req_beats` is ignored and exactly one beat runs.
- R7: On a read, `rdata` takes `mem_rdata` at the last strobe clock of each beat. `beat_done` is high for one clock right after each beat's strobe ends.
- R8: Only `mem_wr_strb` toggles on writes, and only `mem_rd_strb` toggles on reads. `mem_dout_en` is high while the select is active on a write. The first beat's `mem_wdata` comes from `req_wdata` at acceptance. Each later page beat takes `req_wdata` at the edge that ends the inter-beat clock.
- R9: With polarity 0 the strobes are active low, and with polarity 1 they are active high. While no strobe is active, both strobes sit at the inactive level of the channel last accepted (high after reset).
- R10: Channels 0 to 5 drive `cs_n[ch]` low while selected. Channels 6 and 7 drive `cs_int[ch-6]` high while selected and touch no pin. At most one select is active at a time.
- R11: After reset, `req_ready`=1, all `cs_n`=1, `cs_int`=0, both strobes are high, and `ack`, `beat_done` and `mem_dout_en` are 0.
- R12: `ack` is high for exactly one clock per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel whose register is written |
| cfg_data | input | 16 | Configuration value (layout in R1) |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ch | input | 3 | Requested channel |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Start address |
| req_wdata | input | 16 | Write data for the first or next beat |
| req_beats | input | 2 | Page beats minus one |
| ack | output | 1 | One-clock completion pulse |
| beat_done | output | 1 | One-clock pulse after each beat's strobe |
| rdata | output | 16 | Last captured read data |
| cs_n | output | 6 | Active-low selects, channels 0 to 5 |
| cs_int | output | 2 | Internal active-high selects, channels 6 and 7 |
| mem_rd_strb | output | 1 | Read (output-enable) strobe, polarity per channel |
| mem_wr_strb | output | 1 | Write strobe, polarity per channel |
| mem_addr | output | 16 | External address |
| mem_wdata | output | 16 | External write data |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_rdata | input | 16 | External read data |

## Verification
On every cycle, the assertions guard the structural rules: at most one select is active, a strobe never shows without a select, read and write strobes never overlap, the address does not move within a strobe, the data drive only accompanies a write select, `ack` lasts one clock with everything released, and acceptance drops `req_ready`. The exact interval lengths (setup, strobe, hold, page gaps, totals), the per-channel parameter use, the latching of configuration at acceptance, the ignoring of beat counts outside page mode, polarity levels and captured data are only shown by the bench's sweeps, which compute each expected count arithmetically from the written configuration.

// File: rtl/amem_pkg.sv
package amem_pkg;

  localparam int unsigned AMEM_WAIT_W = 8;
  localparam int unsigned AMEM_SH_W   = 6;

  typedef struct packed {
    logic                   strb_pol;
    logic                   page_en;
    logic [AMEM_SH_W-1:0]   sh_cnt;
    logic [AMEM_WAIT_W-1:0] wait_cnt;
  } amem_cfg_t;

  localparam int unsigned AMEM_CFG_W = $bits(amem_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_GAP    = 3'd3,
    ST_HOLD   = 3'd4,
    ST_DONE   = 3'd5
  } amem_state_e;

endpackage

// File: rtl/amem_cfg_regs.sv
module amem_cfg_regs
  import amem_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  amem_cfg_t       wr_cfg,
  input  logic [CH_W-1:0] rd_ch,
  output amem_cfg_t       rd_cfg
);

  logic [NUM_CH-1:0][AMEM_CFG_W-1:0] cfg_flat;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    amem_cfg_t chan_q;
    logic      chan_we;

    assign chan_we = wr_en && (wr_ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_q <= '0;
      end else if (chan_we) begin
        chan_q <= wr_cfg;
      end
    end

    assign cfg_flat[g] = chan_q;
  end

  assign rd_cfg = amem_cfg_t'(cfg_flat[rd_ch]);

endmodule

// File: rtl/amem_cycle_fsm.sv
module amem_cycle_fsm
  import amem_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BEAT_W = 2,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_ch,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BEAT_W-1:0] req_beats,
  input  amem_cfg_t         sel_cfg,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              req_ready,
  output logic              sel_on,
  output logic [CH_W-1:0]   sel_ch,
  output logic              rd_act,
  output logic              wr_act,
  output logic              strb_pol,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              dout_en,
  output logic [DATA_W-1:0] rdata,
  output logic              beat_done,
  output logic              ack
);

  localparam int unsigned CNT_W = (AMEM_WAIT_W > AMEM_SH_W) ? AMEM_WAIT_W : AMEM_SH_W;

  amem_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beats_q, beats_d;

  amem_cfg_t         cfg_q;
  logic [CH_W-1:0]   ch_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              beat_done_q;

  logic accept;
  logic cap;
  logic adv;

  // Next-state logic of the shared cycle engine
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beats_d = beats_q;
    accept  = 1'b0;
    cap     = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          beats_d = sel_cfg.page_en ? req_beats : '0;
          if (!sel_cfg.page_en && (sel_cfg.sh_cnt != '0)) begin
            state_d = ST_SETUP;
            cnt_d   = CNT_W'(sel_cfg.sh_cnt) - 1'b1;
          end else begin
            state_d = ST_STROBE;
            cnt_d   = CNT_W'(sel_cfg.wait_cnt);
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_STROBE;
          cnt_d   = CNT_W'(cfg_q.wait_cnt);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          cap = 1'b1;
          if (beats_q != '0) begin
            state_d = ST_GAP;
          end else if (!cfg_q.page_en && (cfg_q.sh_cnt != '0)) begin
            state_d = ST_HOLD;
            cnt_d   = CNT_W'(cfg_q.sh_cnt) - 1'b1;
          end else begin
            state_d = ST_DONE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        adv     = 1'b1;
        state_d = ST_STROBE;
        cnt_d   = CNT_W'(cfg_q.wait_cnt);
        beats_d = beats_q - 1'b1;
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Sequence registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beats_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beats_q <= beats_d;
    end
  end

  // Access context, loaded on acceptance, stepped on each page beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ch_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cfg_q   <= sel_cfg;
      ch_q    <= req_ch;
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end else if (adv) begin
      addr_q  <= addr_q + 1'b1;
      wdata_q <= req_wdata;
    end
  end

  // Read capture at the last strobe clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap && !wr_q) begin
      rdata_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_done_q <= 1'b0;
    end else begin
      beat_done_q <= cap;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign sel_on    = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                     (state_q == ST_GAP)   || (state_q == ST_HOLD);
  assign sel_ch    = ch_q;
  assign rd_act    = (state_q == ST_STROBE) && !wr_q;
  assign wr_act    = (state_q == ST_STROBE) && wr_q;
  assign strb_pol  = cfg_q.strb_pol;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign dout_en   = sel_on && wr_q;
  assign rdata     = rdata_q;
  assign beat_done = beat_done_q;
  assign ack       = (state_q == ST_DONE);

endmodule

// File: rtl/amem_sel_map.sv
module amem_sel_map #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PIN_CH = 6,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic                     sel_on,
  input  logic [CH_W-1:0]          sel_ch,
  output logic [PIN_CH-1:0]        cs_n,
  output logic [NUM_CH-PIN_CH-1:0] cs_int
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    logic hit;
    assign hit = sel_on && (sel_ch == CH_W'(g));
    if (g < PIN_CH) begin : g_pin
      assign cs_n[g] = ~hit;
    end else begin : g_int
      assign cs_int[g-PIN_CH] = hit;
    end
  end

endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
  import amem_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PIN_CH = 6,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BEAT_W = 2,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned INT_CH = NUM_CH - PIN_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CH_W-1:0]       cfg_ch,
  input  logic [AMEM_CFG_W-1:0] cfg_data,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [CH_W-1:0]       req_ch,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [BEAT_W-1:0]     req_beats,
  output logic                  ack,
  output logic                  beat_done,
  output logic [DATA_W-1:0]     rdata,
  output logic [PIN_CH-1:0]     cs_n,
  output logic [INT_CH-1:0]     cs_int,
  output logic                  mem_rd_strb,
  output logic                  mem_wr_strb,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  mem_dout_en,
  input  logic [DATA_W-1:0]     mem_rdata
);

  amem_cfg_t       sel_cfg;
  logic            sel_on;
  logic [CH_W-1:0] sel_ch;
  logic            rd_act;
  logic            wr_act;
  logic            strb_pol;

  amem_cfg_regs #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_ch  (cfg_ch),
    .wr_cfg (amem_cfg_t'(cfg_data)),
    .rd_ch  (req_ch),
    .rd_cfg (sel_cfg)
  );

  amem_cycle_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BEAT_W (BEAT_W),
    .CH_W   (CH_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ch    (req_ch),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_beats (req_beats),
    .sel_cfg   (sel_cfg),
    .mem_rdata (mem_rdata),
    .req_ready (req_ready),
    .sel_on    (sel_on),
    .sel_ch    (sel_ch),
    .rd_act    (rd_act),
    .wr_act    (wr_act),
    .strb_pol  (strb_pol),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dout_en   (mem_dout_en),
    .rdata     (rdata),
    .beat_done (beat_done),
    .ack       (ack)
  );

  amem_sel_map #(
    .NUM_CH (NUM_CH),
    .PIN_CH (PIN_CH),
    .CH_W   (CH_W)
  ) u_sel (
    .sel_on (sel_on),
    .sel_ch (sel_ch),
    .cs_n   (cs_n),
    .cs_int (cs_int)
  );

  // Polarity: 0 -> active low, 1 -> active high
  assign mem_rd_strb = strb_pol ? rd_act : ~rd_act;
  assign mem_wr_strb = strb_pol ? wr_act : ~wr_act;

endmodule

// File: rtl/amem_ctrl_chk.sv
module amem_ctrl_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PIN_CH = 6,
  parameter int unsigned ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PIN_CH-1:0]        cs_n,
  input logic [NUM_CH-PIN_CH-1:0] cs_int,
  input logic                     rd_act,
  input logic                     wr_act,
  input logic                     ack,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic                     mem_dout_en
);

  logic any_sel;
  logic strb;
  assign any_sel = (|(~cs_n)) || (|cs_int);
  assign strb    = rd_act || wr_act;

  assert_one_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_int, ~cs_n}));

  assert_strobe_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> any_sel);

  assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_act && wr_act));

  assert_dout_only_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (any_sel && !rd_act));

  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!any_sel && !strb));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(strb)) |-> $stable(mem_addr));

endmodule

bind amem_ctrl amem_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .PIN_CH (PIN_CH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .cs_int      (cs_int),
  .rd_act      (rd_act),
  .wr_act      (wr_act),
  .ack         (ack),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_addr    (mem_addr),
  .mem_dout_en (mem_dout_en)
);

// File: tb/amem_ctrl_bench.sv
`timescale 1ns/1ps
module amem_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_ch;
  logic [15:0] cfg_data;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_ch;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_beats;
  logic        ack;
  logic        beat_done;
  logic [15:0] rdata;
  logic [5:0]  cs_n;
  logic [1:0]  cs_int;
  logic        mem_rd_strb;
  logic        mem_wr_strb;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_dout_en;
  logic [15:0] mem_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc_cnt = 0;

  int sh_s   [8];
  int wait_s [8];
  int page_s [8];
  int pol_s  [8];

  amem_ctrl u_amem_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_beats(req_beats), .ack(ack),
    .beat_done(beat_done), .rdata(rdata), .cs_n(cs_n), .cs_int(cs_int),
    .mem_rd_strb(mem_rd_strb), .mem_wr_strb(mem_wr_strb), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_dout_en(mem_dout_en), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem_addr ^ 16'h5A3C;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=150000", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit sel_of(input int ch);
    return (ch < 6) ? !cs_n[ch] : cs_int[ch-6];
  endfunction

  task automatic set_cfg(input int ch, input int pol, input int page, input int sh, input int wt);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_ch   = 3'(ch);
    cfg_data = {1'(pol), 1'(page), 6'(sh), 8'(wt)};
    @(negedge clk);
    cfg_we   = 1'b0;
    sh_s[ch] = sh; wait_s[ch] = wt; page_s[ch] = page; pol_s[ch] = pol;
  endtask

  // One access; expected values derived from the shadow configuration
  task automatic access(input int ch, input bit wr, input logic [15:0] addr,
                        input logic [15:0] base, input int bm1, input string tag,
                        input bit mid_cfg, input int mid_sh, input int mid_wt);
    int sh = sh_s[ch];
    int wt = wait_s[ch];
    int pg = page_s[ch];
    int pol = pol_s[ch];
    int nb = pg ? bm1 + 1 : 1;
    int e_setup = pg ? 0 : sh;
    int e_strb  = nb * (wt + 1);
    int e_gap   = nb - 1;
    int e_total = pg ? (nb * (wt + 1) + nb) : (2 * sh + wt + 2);
    int n_setup = 0, n_strb = 0, n_gap = 0, pend = 0, n_tot = 0;
    int beat = 0, nbd = 0, errs = 0, other = 0, wrong = 0;
    bit seen = 0, prev_strb = 0, fin = 0, s, sel;
    @(negedge clk);
    req_valid = 1'b1; req_ch = 3'(ch); req_write = wr; req_addr = addr;
    req_wdata = base; req_beats = 2'(bm1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin) begin
      n_tot++;
      sel = sel_of(ch);
      other += ($countones(~cs_n) + $countones(cs_int)) - int'(sel);
      s = wr ? (mem_wr_strb == 1'(pol)) : (mem_rd_strb == 1'(pol));
      if (wr ? (mem_rd_strb == 1'(pol)) : (mem_wr_strb == 1'(pol))) wrong++;
      if (sel && s) begin
        if (!prev_strb) begin
          beat++;
          if (seen) begin n_gap += pend; pend = 0; end
        end
        seen = 1;
        n_strb++;
        if (mem_addr != addr + 16'(beat - 1)) errs++;
        if (wr && (mem_wdata != base + 16'(beat - 1) || !mem_dout_en)) errs++;
      end else if (sel) begin
        if (!seen) n_setup++; else pend++;
      end
      if (beat_done) begin
        nbd++;
        if (!wr && rdata != ((addr + 16'(nbd - 1)) ^ 16'h5A3C)) errs++;
        if (wr) req_wdata = base + 16'(nbd);
      end
      if (mid_cfg && n_tot == 1) begin
        cfg_we = 1'b1; cfg_ch = 3'(ch);
        cfg_data = {1'(pol), 1'(pg), 6'(mid_sh), 8'(mid_wt)};
      end
      if (mid_cfg && n_tot == 2) cfg_we = 1'b0;
      prev_strb = s;
      if (ack) begin
        fin = 1;
        chk(!sel && other == 0, "R3", "select released at ack", int'(sel), 0);
        chk(mem_rd_strb == !pol && mem_wr_strb == !pol, "R9", "idle strobe level",
            int'({mem_rd_strb, mem_wr_strb}), pol ? 0 : 3);
      end else if (n_tot > 2000) begin
        fin = 1;
        chk(0, tag, "no ack", n_tot, e_total);
      end
      if (!fin) @(negedge clk);
    end
    chk(n_setup == e_setup, pg ? "R5" : "R3", "setup clocks", n_setup, e_setup);
    chk(n_strb == e_strb, "R3", "strobe clocks", n_strb, e_strb);
    chk(n_gap == e_gap, "R5", "gap clocks", n_gap, e_gap);
    chk(pend == e_setup, pg ? "R5" : "R3", "hold clocks", pend, e_setup);
    chk(n_tot == e_total, tag, "clocks to ack", n_tot, e_total);
    chk(nbd == nb && beat == nb, pg ? "R5" : "R6", "beat count", nbd, nb);
    chk(other == 0, "R10", "foreign select active", other, 0);
    chk(wrong == 0, "R8", "wrong strobe active", wrong, 0);
    chk(errs == 0, wr ? "R8" : "R7", "address/data mismatches", errs, 0);
    @(negedge clk);
    chk(!ack, "R12", "ack width", int'(ack), 0);
    chk(req_ready, "R2", "ready after ack", int'(req_ready), 1);
    if (mid_cfg) begin sh_s[ch] = mid_sh; wait_s[ch] = mid_wt; end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_data = '0;
    req_valid = 1'b0; req_ch = '0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_beats = '0;
    for (int i = 0; i < 8; i++) begin sh_s[i] = 0; wait_s[i] = 0; page_s[i] = 0; pol_s[i] = 0; end
    #5;
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready", int'(req_ready), 1);
    chk(cs_n == 6'h3F, "R11", "cs_n", int'(cs_n), 63);
    chk(cs_int == 2'b00, "R11", "cs_int", int'(cs_int), 0);
    chk(mem_rd_strb && mem_wr_strb, "R11", "strobes", int'({mem_rd_strb, mem_wr_strb}), 3);
    chk(!ack && !beat_done, "R11", "ack/beat_done", int'({ack, beat_done}), 0);
    chk(!mem_dout_en, "R11", "dout_en", int'(mem_dout_en), 0);
    #40;
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R10 / R9: distinct configuration per channel, every channel used
    for (int c = 0; c < 8; c++) set_cfg(c, c % 2, 0, c % 3, c + 1);
    for (int c = 0; c < 8; c++) begin
      access(c, 1'b0, 16'(16'h0100 * c + 3), 16'h0, 0, "R1", 0, 0, 0);
      access(c, 1'b1, 16'(16'h0200 * c + 7), 16'(16'hC000 + c), 0, "R1", 0, 0, 0);
    end

    // R3 sweep of setup/hold and wait
    for (int sh = 0; sh < 5; sh++) begin
      for (int w = 0; w < 4; w++) begin
        int c = (sh + w) % 8;
        set_cfg(c, w % 2, 0, sh, w * w * 2);
        access(c, 1'b0, 16'(sh * 64 + w), 16'h0, 0, "R3", 0, 0, 0);
        access(c, 1'b1, 16'(sh * 32 + w), 16'(16'hA000 + sh * 16 + w), 0, "R3", 0, 0, 0);
      end
    end

    // R3 extremes: shortest and longest access
    set_cfg(0, 0, 0, 0, 0);
    access(0, 1'b0, 16'h1234, 16'h0, 0, "R3", 0, 0, 0);
    set_cfg(7, 1, 0, 63, 255);
    access(7, 1'b1, 16'hFFFE, 16'hBEEF, 0, "R3", 0, 0, 0);

    // R5 page mode: setup/hold programmed but skipped
    for (int w = 0; w < 2; w++) begin
      set_cfg(5, w, 1, 7, w * 3);
      for (int b = 0; b < 4; b++) begin
        access(5, 1'b0, 16'(16'h4000 + b * 8), 16'h0, b, "R5", 0, 0, 0);
        access(5, 1'b1, 16'(16'hFFFE), 16'(16'h7700 + b * 16), b, "R5", 0, 0, 0);
      end
    end

    // R6 beat count ignored without page mode
    set_cfg(4, 0, 0, 2, 1);
    access(4, 1'b0, 16'h2222, 16'h0, 3, "R6", 0, 0, 0);
    access(4, 1'b1, 16'h2223, 16'h5555, 2, "R6", 0, 0, 0);

    // R4 configuration change during an access
    set_cfg(1, 0, 0, 2, 3);
    access(1, 1'b0, 16'h3000, 16'h0, 0, "R4", 1, 9, 20);
    access(1, 1'b0, 16'h3001, 16'h0, 0, "R4", 0, 0, 0);

    // R2 request held while busy
    begin
      int bad = 0;
      int guard = 0;
      set_cfg(3, 0, 0, 1, 2);
      set_cfg(6, 0, 0, 0, 4);
      @(negedge clk);
      req_valid = 1'b1; req_ch = 3'd3; req_write = 1'b0; req_addr = 16'h0600; req_beats = '0;
      @(posedge clk);
      @(negedge clk);
      req_ch = 3'd6;
      while (!ack && guard < 100) begin
        if (req_ready || cs_int[0] || cs_n[3]) bad++;
        guard++;
        @(negedge clk);
      end
      chk(bad == 0 && guard == 5, "R2", "held request disturbed busy access", bad + guard * 100, 500);
      @(negedge clk);
      chk(req_ready && cs_int == 2'b00, "R2", "idle between accesses", int'({req_ready, cs_int}), 4);
      @(negedge clk);
      chk(!req_ready && cs_int[0], "R2", "held request taken after ack", int'({req_ready, cs_int}), 1);
      req_valid = 1'b0;
      guard = 0;
      while (!ack && guard < 100) begin guard++; @(negedge clk); end
      chk(guard == 5, "R2", "held access length", guard, 5);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule